// File: doc/BRIEF.md
# Static LCD Segment Driver for a Three-and-a-Half Digit Counter

This block holds the counting and display end of a panel meter. A chain of BCD decades counts enabled clock ticks. Each tick is a fixed number of system clock cycles. On a one-cycle end-of-conversion strobe, the block captures the count and the sign, then restarts the counters from zero. The captured value is decoded to seven-segment patterns for the ones, tens and hundreds digits. The thousands position is a single "1" that lights two segment lines, and a separate line drives the minus sign.

The display is a static LCD, so every segment needs an AC drive with no net DC across it. The block derives a 50% square-wave backplane from the system clock. An unlit segment line follows the backplane. A lit segment line is its complement. A lamp-test input forces every segment line to a steady high level so that the whole display can be inspected.

Top module: `lcd_static_drv`

## Requirements
- R1: After reset, every counter and captured value is zero and the backplane is low. The display therefore shows the pattern for 000, with the thousands and minus lines dark.
- R2: The counters advance by one for each PRE_DIV (default 4) clock cycles that `cntEn` is high. A partial group of fewer than PRE_DIV enabled cycles before a strobe adds nothing.
- R3: The ones, tens and hundreds digits count in BCD (0 to 9). Each digit passes a carry to the next one when it wraps from 9 to 0.
- R4: A carry out of the hundreds digit sets a thousands flag, which stays set until the next strobe. The flag drives both thousands lines (`segThou[1:0]`, the b and c segments of a "1") identically.
- R5: On the clock edge where `eocStrobe` is high, the display captures the current count. In the same edge the counters and the tick prescaler return to zero. Between strobes, the display does not follow the counters.
- R6: The sign is taken from `negIn` only on the strobe edge. The minus line is lit when that captured bit is 1, and `negIn` has no effect at other times.
- R7: The backplane is a 50% square wave that changes level every PRE_DIV*BP_DIV/2 clock cycles (default 400), giving a period of 800 cycles.
- R8: A dark segment line equals `backplane`, and a lit segment line equals its inverse, in both phases of the backplane.
- R9: While `lampTest` is high, all 24 segment lines (digits, thousands pair and minus) are held at constant 1 regardless of the backplane. Releasing it restores the captured display.
- R10: Digit patterns are active high before the backplane stage, with bit 0 = a through bit 6 = g. The values for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). `segDigits[6:0]` carries the ones digit, `[13:7]` the tens digit and `[20:14]` the hundreds digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Counting enable; each PRE_DIV high cycles make one count |
| eocStrobe | input | 1 | One-cycle end-of-conversion strobe: capture and restart |
| negIn | input | 1 | Sign of the result, sampled on the strobe |
| lampTest | input | 1 | Forces all segment lines to steady high |
| segDigits | output | 21 | Segment lines for ones, tens and hundreds digits |
| segThou | output | 2 | Thousands "1" segment lines (b and c) |
| segMinus | output | 1 | Minus-sign segment line |
| backplane | output | 1 | Backplane square wave |

## Verification
The bench drives enable windows that end exactly on tick boundaries and one window that stops one cycle short of a tick. A prescaler that fails to restart on the strobe, or that counts partial groups, shows up as a display that is off by one. Counts of 99, 999, 1000, 1999 and 2005 exercise every carry path and the sticky thousands flag. A design that drops a carry shows a wrapped digit with no increment above it. A flag that clears on wrap shows a dark "1" at 2005. Each captured value is observed in both backplane phases and again after the counters have moved on. An inverted phase, or a display that tracks the live counters, fails one of those comparisons. The sign input is toggled against its captured value during counting, and lamp test is held across a backplane edge to catch a lamp-test output that still switches.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic countTick;   // one count of the decade chain
    logic bpToggle;    // backplane changes level at this edge
    logic latchLoad;   // capture display, restart counters
  } drvStrobes_t;

  // active-high seven-segment map, bit0 = a ... bit6 = g
  function automatic logic [6:0] digitToSeg(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lcd_drv_ctrl.sv
module lcd_drv_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int PRE_DIV = 4,
  parameter int BP_DIV  = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntEn,
  input  logic        eocStrobe,
  output drvStrobes_t strobes,
  output logic        backplane
);

  localparam int BP_HALF = PRE_DIV * BP_DIV / 2;
  localparam int PRE_W   = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int BP_W    = (BP_HALF > 2) ? $clog2(BP_HALF) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [BP_W-1:0]  BP_LAST  = BP_W'(BP_HALF - 1);

  logic [PRE_W-1:0] preCnt;
  logic [BP_W-1:0]  bpCnt;
  logic             bpLevel;

  // count prescaler: runs only while counting, restarts on the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (eocStrobe) begin
      preCnt <= '0;
    end else if (cntEn) begin
      preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
    end
  end

  // backplane divider: free running from the system clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpCnt   <= '0;
      bpLevel <= 1'b0;
    end else if (bpCnt == BP_LAST) begin
      bpCnt   <= '0;
      bpLevel <= ~bpLevel;
    end else begin
      bpCnt   <= bpCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.countTick = cntEn && !eocStrobe && (preCnt == PRE_LAST);
    strobes.bpToggle  = (bpCnt == BP_LAST);
    strobes.latchLoad = eocStrobe;
  end

  assign backplane = bpLevel;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countTick |=> !strobes.countTick);                          // R2
  AST_BP_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.bpToggle |=> $stable(backplane));                          // R7
  AST_BP_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bpToggle |=> (backplane != $past(backplane)));              // R7

endmodule

// File: rtl/lcd_drv_datapath.sv
module lcd_drv_datapath
  import lcd_drv_pkg::*;
#(
  parameter int NUM_FULL = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  drvStrobes_t             strobes,
  input  logic                    backplane,
  input  logic                    negIn,
  input  logic                    lampTest,
  output logic [NUM_FULL*7-1:0]   segDigits,
  output logic [1:0]              segThou,
  output logic                    segMinus
);

  localparam int SEG_W = 7;

  logic [3:0]        cntDigit [NUM_FULL];
  logic [3:0]        latDigit [NUM_FULL];
  logic [SEG_W-1:0]  segPat   [NUM_FULL];
  logic [NUM_FULL:0] carryChain;
  logic              thouFlag;
  logic              latThou;
  logic              latNeg;

  assign carryChain[0] = strobes.countTick;

  // BCD decade chain with ripple carry
  for (genvar g = 0; g < NUM_FULL; g++) begin : gDecade
    assign carryChain[g+1] = carryChain[g] && (cntDigit[g] == 4'd9);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntDigit[g] <= '0;
      end else if (strobes.latchLoad) begin
        cntDigit[g] <= '0;
      end else if (carryChain[g]) begin
        cntDigit[g] <= (cntDigit[g] == 4'd9) ? 4'd0 : cntDigit[g] + 4'd1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latDigit[g] <= '0;
      end else if (strobes.latchLoad) begin
        latDigit[g] <= cntDigit[g];
      end
    end

    assign segPat[g] = digitToSeg(latDigit[g]);

    always_comb begin
      if (lampTest) begin
        segDigits[g*SEG_W +: SEG_W] = '1;
      end else begin
        segDigits[g*SEG_W +: SEG_W] = segPat[g] ^ {SEG_W{backplane}};
      end
    end

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      cntDigit[g] <= 4'd9);                                             // R3
    AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.latchLoad |=> $stable(latDigit[g]));                     // R5
    AST_CLEAR_ON_EOC: assert property (@(posedge clk) disable iff (!rstN)
      strobes.latchLoad |=> (cntDigit[g] == 4'd0));                     // R5
  end

  // sticky thousands flag fed by the hundreds carry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thouFlag <= 1'b0;
    end else if (strobes.latchLoad) begin
      thouFlag <= 1'b0;
    end else if (carryChain[NUM_FULL]) begin
      thouFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latThou <= 1'b0;
      latNeg  <= 1'b0;
    end else if (strobes.latchLoad) begin
      latThou <= thouFlag;
      latNeg  <= negIn;
    end
  end

  always_comb begin
    if (lampTest) begin
      segThou  = 2'b11;
      segMinus = 1'b1;
    end else begin
      segThou  = {2{latThou ^ backplane}};
      segMinus = latNeg ^ backplane;
    end
  end

  AST_THOU_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (thouFlag && !strobes.latchLoad) |=> thouFlag);                     // R4
  AST_THOU_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    segThou[0] == segThou[1]);                                          // R4
  AST_SIGN_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchLoad |=> $stable(latNeg));                            // R6
  AST_LAMP_ALL: assert property (@(posedge clk) disable iff (!rstN)
    lampTest |-> (&{segDigits, segThou, segMinus}));                    // R9

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int PRE_DIV  = 4,
  parameter int BP_DIV   = 200,
  parameter int NUM_FULL = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cntEn,
  input  logic                  eocStrobe,
  input  logic                  negIn,
  input  logic                  lampTest,
  output logic [NUM_FULL*7-1:0] segDigits,
  output logic [1:0]            segThou,
  output logic                  segMinus,
  output logic                  backplane
);

  drvStrobes_t strobes;

  lcd_drv_ctrl #(
    .PRE_DIV (PRE_DIV),
    .BP_DIV  (BP_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntEn     (cntEn),
    .eocStrobe (eocStrobe),
    .strobes   (strobes),
    .backplane (backplane)
  );

  lcd_drv_datapath #(
    .NUM_FULL (NUM_FULL)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .backplane (backplane),
    .negIn     (negIn),
    .lampTest  (lampTest),
    .segDigits (segDigits),
    .segThou   (segThou),
    .segMinus  (segMinus)
  );

endmodule

// File: tb/lcd_static_drv_bench.sv
module lcd_static_drv_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_DIV    = 4;
  localparam int BP_HALF    = 400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic        eocStrobe = 1'b0;
  logic        negIn = 1'b0;
  logic        lampTest = 1'b0;
  logic [20:0] segDigits;
  logic [1:0]  segThou;
  logic        segMinus;
  logic        backplane;

  typedef struct {
    int    value;
    bit    neg;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastItem;
  int checkCnt = 0;
  int failCnt  = 0;
  int pendingCycles = 0;
  int edgeCnt = 0;
  logic prevBp = 1'b0;
  bit bpWatch = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_static_drv u_lcd_static_drv (
    .clk       (clk),
    .rstN      (rstN),
    .cntEn     (cntEn),
    .eocStrobe (eocStrobe),
    .negIn     (negIn),
    .lampTest  (lampTest),
    .segDigits (segDigits),
    .segThou   (segThou),
    .segMinus  (segMinus),
    .backplane (backplane)
  );

  function automatic logic [6:0] refSeg(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
      3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
      6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
      default: return 7'h6F;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard compare of the whole display against a count value
  task automatic compareDisplay(input expItem_t e);
    logic [20:0] expDig;
    logic [1:0]  expThou;
    logic        expMinus;
    int v;
    v = e.value;
    expDig = {refSeg((v / 100) % 10), refSeg((v / 10) % 10), refSeg(v % 10)}
             ^ {21{backplane}};
    expThou  = {2{(v >= 1000) ^ backplane}};
    expMinus = e.neg ^ backplane;
    check(segDigits === expDig, e.req, "digits (R10 R8)", 32'(segDigits), 32'(expDig));
    check(segThou === expThou, e.req, "thousands (R4 R8)", 32'(segThou), 32'(expThou));
    check(segMinus === expMinus, e.req, "minus (R6 R8)", 32'(segMinus), 32'(expMinus));
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    expItem_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      compareDisplay(e);
    end
  end

  // backplane interval monitor (R7)
  always @(posedge clk) if (rstN) edgeCnt++;
  always @(negedge clk) begin
    if (bpWatch && (backplane !== prevBp)) begin
      check(edgeCnt == BP_HALF, "R7", "backplane half period", 32'(edgeCnt), 32'(BP_HALF));
      edgeCnt = 0;
    end
    prevBp = backplane;
  end

  task automatic runCycles(input int c, input bit wrongSign);
    @(negedge clk);
    negIn = wrongSign;
    cntEn = 1'b1;
    repeat (c) @(negedge clk);
    cntEn = 1'b0;
    pendingCycles += c;
  endtask

  task automatic convert(input bit neg, input string req);
    expItem_t e;
    negIn = neg;
    eocStrobe = 1'b1;
    @(posedge clk);
    e.value = pendingCycles / PRE_DIV;
    e.neg = neg;
    e.req = req;
    pendingCycles = 0;
    expQ.push_back(e);
    lastItem = e;
    @(negedge clk);
    eocStrobe = 1'b0;
    negIn = 1'b0;
  endtask

  task automatic countAndConvert(input int n, input bit neg, input string req);
    runCycles(n * PRE_DIV, ~neg);
    convert(neg, req);
  endtask

  task automatic recheckLast(input string req);
    expItem_t e;
    @(posedge clk);
    e = lastItem;
    e.req = req;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    expItem_t e;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(backplane === 1'b0, "R1", "backplane in reset", 32'(backplane), 32'd0);
    rstN = 1'b1;
    edgeCnt = 0;
    bpWatch = 1'b1;
    e.value = 0; e.neg = 1'b0; e.req = "R1";
    lastItem = e;
    recheckLast("R1");

    countAndConvert(7, 1'b0, "R2");
    countAndConvert(1, 1'b1, "R6");
    runCycles(PRE_DIV - 1, 1'b1);       // partial group: no count
    convert(1'b0, "R2");
    runCycles(2 * PRE_DIV + 1, 1'b0);   // R5 prescaler restart: expect 2
    convert(1'b0, "R5");
    countAndConvert(99, 1'b0, "R3");
    countAndConvert(100, 1'b1, "R3");
    countAndConvert(385, 1'b1, "R10");
    countAndConvert(999, 1'b0, "R3");
    countAndConvert(1000, 1'b0, "R4");
    countAndConvert(1999, 1'b1, "R4");
    countAndConvert(2005, 1'b0, "R4");

    // R5: display holds while counters move
    runCycles(37 * PRE_DIV, 1'b1);
    recheckLast("R5");
    // R8: same value in the other backplane phase
    repeat (BP_HALF) @(negedge clk);
    recheckLast("R8");
    runCycles(3 * PRE_DIV, 1'b0);
    convert(1'b0, "R5");                // 37 + 3 = 40

    // R9: lamp test, steady across a backplane edge
    @(negedge clk);
    lampTest = 1'b1;
    @(negedge clk);
    check((&{segDigits, segThou, segMinus}) === 1'b1, "R9", "lamp test all on",
          32'({segMinus, segThou, segDigits}), 32'h00FFFFFF);
    repeat (BP_HALF) @(negedge clk);
    check((&{segDigits, segThou, segMinus}) === 1'b1, "R9", "lamp test other phase",
          32'({segMinus, segThou, segDigits}), 32'h00FFFFFF);
    lampTest = 1'b0;
    recheckLast("R9");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule